// File: doc/BRIEF.md
# Radix Translation Front-End

This block takes one address translation request at a time and works out how it is to be served before any page-table walk begins. An access made in hypervisor state with relocation switched off for its type is finished at once as a real-mode access. Any other access is split by the two most significant effective-address bits (the quadrant). Together with the hypervisor state, the quadrant selects which partition identifier and which process identifier apply. Guest accesses to the two middle quadrants stop with a segment fault.

For a legal access the block reads two doublewords of the partition entry and checks them. It then bounds the process identifier against the size of the process table and reads the first doubleword of that process's entry. From that doubleword it hands a root directory base, a root entry-count exponent and an address-size exponent to a separate radix walker, which it starts with a one-cycle pulse. When the walker reports back, the block returns a one-cycle `done` with a fault code. All memory traffic goes through a single read port with one read outstanding. The memory answers each `mem_req` with a later `mem_rvalid`.

Top module: `xlate_front`

## Requirements
- R1: During and after reset, `done`, `busy`, `mem_req` and `walk_start` are low and `resp_fault` is 0.
- R2: Access kinds are 0 load, 1 store and 2 fetch. When `hv_mode` is 1 and the access is a fetch with `ir_on` 0, or a load or store with `dr_on` 0, `done` rises in the cycle after acceptance with fault 0. In that case `resp_raddr` equals the effective address with bits 63:60 cleared, `resp_perm` is 3'b111, and no memory read is made.
- R3: In hypervisor state, quadrant `ea[63:62]` selects the identifiers as follows: 0 gives partition 0 and the current process, 1 gives the current partition and the current process, 2 gives the current partition and process 0, and 3 gives partition 0 and process 0. The partition entry is read at `ptab_base + lpid*16` (first doubleword) and then at `+8`. The process entry is read at `process-table base + pid*16`.
- R4: In guest state, quadrant 0 gives the current partition and the current process, and quadrant 3 gives the current partition and process 0. `ir_on` and `dr_on` are not consulted.
- R5: In guest state, quadrants 1 and 2 finish with fault code 1 (segment) and no memory read. For any fault on a load or store, `resp_dar_valid` is 1 and `resp_dar` is the effective address. For a fetch, `resp_dar_valid` is 0.
- R6: If bit 63 of the first partition doubleword (radix flag) is 0, the request finishes with fault code 3 (bad configuration) after exactly one read.
- R7: Partition 0 resolved in guest state finishes with fault code 3.
- R8: The second partition doubleword holds the process-table base in bits PA_W-1:12 and a size field in bits 4:0. If pid*16 is at least 2^(size+12), the request finishes with fault code 2 (no entry) after exactly two reads. One entry below the limit is translated.
- R9: The process-entry doubleword gives `walk_root` = bits PA_W-1:8 with 8 low zero bits, `walk_nls` = bits 4:0 and `walk_asize` = bits 63:58. `walk_ea` is the request address, and `walk_start` is a single-cycle pulse.
- R10: On `walk_done`, the block finishes with fault 0, `resp_raddr` = `walk_raddr` and `resp_perm` = 0 if `walk_ok` is 1. Otherwise it finishes with fault code 4 and `resp_raddr` = 0.
- R11: `busy` is high from acceptance until `done`. Requests seen while busy are dropped. `mem_req` is a single-cycle pulse made only while busy, and the response outputs hold their value between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when idle |
| req_ea | input | 64 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| hv_mode | input | 1 | Hypervisor state |
| ir_on | input | 1 | Instruction relocation enabled |
| dr_on | input | 1 | Data relocation enabled |
| cur_lpid | input | LPID_W | Current partition identifier |
| cur_pid | input | PID_W | Current process identifier |
| ptab_base | input | PA_W | Partition table base address |
| busy | output | 1 | Request in progress |
| mem_req | output | 1 | Doubleword read request pulse |
| mem_addr | output | PA_W | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| walk_start | output | 1 | Walker start pulse |
| walk_ea | output | 64 | Address to walk |
| walk_root | output | PA_W | Root directory base |
| walk_nls | output | 5 | Root entry-count exponent |
| walk_asize | output | 6 | Address-size exponent |
| walk_done | input | 1 | Walker finished |
| walk_ok | input | 1 | Walker found a valid leaf |
| walk_raddr | input | 64 | Walker real address |
| done | output | 1 | Response pulse |
| resp_fault | output | 3 | 0 ok, 1 segment, 2 no entry, 3 bad config, 4 walk fault |
| resp_raddr | output | 64 | Real address |
| resp_perm | output | 3 | Permission, nonzero only for real-mode completions |
| resp_dar_valid | output | 1 | Faulting data address recorded |
| resp_dar | output | 64 | Faulting data address |

## Verification
The hardest case to reach is the process-table bound at its exact edge. It needs a legal quadrant, a valid partition entry with a small size field, and a current process identifier placed on and just below the limit. The stimulus sets the size field to 0 and uses process 256 and then 255. It counts reads to confirm that the bound stops the sequence before the third read. The second hard case is a request arriving while a walk is outstanding. It is driven by holding a real-mode request on `req_valid` through the busy window and showing that exactly one response, the walked one, comes out.

// File: rtl/xf_pkg.sv
package xf_pkg;
    localparam int EA_W = 64;
    localparam int DW_W = 64;
    localparam int ENTRY_SHIFT = 4;      // 16-byte table entries
    localparam int RADIX_FLAG_BIT = 63;  // partition doubleword 0
    localparam int PRT_MIN_EXP = 12;     // table size offset

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_SEG    = 3'd1,
        FLT_NOPTE  = 3'd2,
        FLT_BADCFG = 3'd3,
        FLT_WALK   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PART0,
        S_PART1,
        S_PROC,
        S_WALK
    } seq_state_e;
endpackage

// File: rtl/xf_mode.sv
module xf_mode
    import xf_pkg::*;
(
    input  logic            hv,
    input  logic            ir_on,
    input  logic            dr_on,
    input  logic [1:0]      kind,
    input  logic [EA_W-1:0] ea,
    output logic            is_real,
    output logic [EA_W-1:0] real_addr
);
    logic reloc_off;

    always_comb begin
        if (kind == ACC_FETCH) reloc_off = !ir_on;
        else                   reloc_off = !dr_on;
        is_real   = hv && reloc_off;
        real_addr = {4'b0000, ea[EA_W-5:0]};
    end
endmodule

// File: rtl/xf_quadrant.sv
module xf_quadrant #(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic              hv,
    input  logic [1:0]        quad,
    input  logic [LPID_W-1:0] cur_lpid,
    input  logic [PID_W-1:0]  cur_pid,
    output logic              legal,
    output logic [LPID_W-1:0] lpid,
    output logic [PID_W-1:0]  pid
);
    always_comb begin
        legal = 1'b1;
        lpid  = '0;
        pid   = '0;
        if (hv) begin
            unique case (quad)
                2'd0: pid = cur_pid;
                2'd1: begin lpid = cur_lpid; pid = cur_pid; end
                2'd2: lpid = cur_lpid;
                default: ;
            endcase
        end else begin
            unique case (quad)
                2'd0: begin lpid = cur_lpid; pid = cur_pid; end
                2'd3: lpid = cur_lpid;
                default: legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/xf_seq.sv
module xf_seq
    import xf_pkg::*;
#(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20,
    parameter int PA_W   = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic [1:0]        req_kind,
    input  logic              hv_mode,
    input  logic              is_real,
    input  logic [EA_W-1:0]   real_addr,
    input  logic              q_legal,
    input  logic [LPID_W-1:0] q_lpid,
    input  logic [PID_W-1:0]  q_pid,
    input  logic [PA_W-1:0]   ptab_base,
    output logic              busy,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [DW_W-1:0]   mem_rdata,
    output logic              walk_start,
    output logic [EA_W-1:0]   walk_ea,
    output logic [PA_W-1:0]   walk_root,
    output logic [4:0]        walk_nls,
    output logic [5:0]        walk_asize,
    input  logic              walk_done,
    input  logic              walk_ok,
    input  logic [EA_W-1:0]   walk_raddr,
    output logic              done,
    output logic [2:0]        resp_fault,
    output logic [EA_W-1:0]   resp_raddr,
    output logic [2:0]        resp_perm,
    output logic              resp_dar_valid,
    output logic [EA_W-1:0]   resp_dar
);
    localparam int SIZE_W = 5;
    localparam int EXP_W  = SIZE_W + 1;

    typedef struct packed {
        seq_state_e        state;
        logic              mem_req;
        logic [PA_W-1:0]   mem_addr;
        logic [LPID_W-1:0] lpid;
        logic [PID_W-1:0]  pid;
        logic              hv;
        logic [EA_W-1:0]   ea;
        logic [1:0]        kind;
        logic              walk_start;
        logic [PA_W-1:0]   walk_root;
        logic [4:0]        walk_nls;
        logic [5:0]        walk_asize;
        logic              done;
        logic [2:0]        fault;
        logic [EA_W-1:0]   raddr;
        logic [2:0]        perm;
        logic              dar_valid;
        logic [EA_W-1:0]   dar;
    } seq_t;

    seq_t s_d, s_q;

    logic [EA_W-1:0]  pid_off;
    logic [EA_W-1:0]  tbl_lim;
    logic [EXP_W-1:0] tbl_exp;
    logic [PA_W-1:0]  prt_base;

    always_comb begin
        s_d            = s_q;
        s_d.mem_req    = 1'b0;
        s_d.walk_start = 1'b0;
        s_d.done       = 1'b0;

        pid_off  = EA_W'(s_q.pid) << ENTRY_SHIFT;
        tbl_exp  = EXP_W'(mem_rdata[SIZE_W-1:0]) + EXP_W'(PRT_MIN_EXP);
        tbl_lim  = {{(EA_W-1){1'b0}}, 1'b1} << tbl_exp;
        prt_base = {mem_rdata[PA_W-1:PRT_MIN_EXP], {PRT_MIN_EXP{1'b0}}};

        unique case (s_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    s_d.ea   = req_ea;
                    s_d.kind = req_kind;
                    s_d.hv   = hv_mode;
                    s_d.lpid = q_lpid;
                    s_d.pid  = q_pid;
                    if (is_real) begin
                        s_d.done      = 1'b1;
                        s_d.fault     = FLT_NONE;
                        s_d.raddr     = real_addr;
                        s_d.perm      = 3'b111;
                        s_d.dar_valid = 1'b0;
                        s_d.dar       = '0;
                    end else if (!q_legal) begin
                        s_d.done      = 1'b1;
                        s_d.fault     = FLT_SEG;
                        s_d.raddr     = '0;
                        s_d.perm      = 3'b000;
                        s_d.dar_valid = (req_kind != ACC_FETCH);
                        s_d.dar       = (req_kind != ACC_FETCH) ? req_ea : '0;
                    end else begin
                        s_d.mem_req  = 1'b1;
                        s_d.mem_addr = ptab_base + (PA_W'(q_lpid) << ENTRY_SHIFT);
                        s_d.state    = S_PART0;
                    end
                end
            end
            S_PART0: begin
                if (mem_rvalid) begin
                    if (!mem_rdata[RADIX_FLAG_BIT] || (s_q.lpid == '0 && !s_q.hv)) begin
                        s_d.done      = 1'b1;
                        s_d.fault     = FLT_BADCFG;
                        s_d.raddr     = '0;
                        s_d.perm      = 3'b000;
                        s_d.dar_valid = (s_q.kind != ACC_FETCH);
                        s_d.dar       = (s_q.kind != ACC_FETCH) ? s_q.ea : '0;
                        s_d.state     = S_IDLE;
                    end else begin
                        s_d.mem_req  = 1'b1;
                        s_d.mem_addr = s_q.mem_addr + PA_W'(8);
                        s_d.state    = S_PART1;
                    end
                end
            end
            S_PART1: begin
                if (mem_rvalid) begin
                    if (pid_off >= tbl_lim) begin
                        s_d.done      = 1'b1;
                        s_d.fault     = FLT_NOPTE;
                        s_d.raddr     = '0;
                        s_d.perm      = 3'b000;
                        s_d.dar_valid = (s_q.kind != ACC_FETCH);
                        s_d.dar       = (s_q.kind != ACC_FETCH) ? s_q.ea : '0;
                        s_d.state     = S_IDLE;
                    end else begin
                        s_d.mem_req  = 1'b1;
                        s_d.mem_addr = prt_base + pid_off[PA_W-1:0];
                        s_d.state    = S_PROC;
                    end
                end
            end
            S_PROC: begin
                if (mem_rvalid) begin
                    s_d.walk_root  = {mem_rdata[PA_W-1:8], 8'h00};
                    s_d.walk_nls   = mem_rdata[4:0];
                    s_d.walk_asize = mem_rdata[63:58];
                    s_d.walk_start = 1'b1;
                    s_d.state      = S_WALK;
                end
            end
            S_WALK: begin
                if (walk_done) begin
                    s_d.done      = 1'b1;
                    s_d.fault     = walk_ok ? FLT_NONE : FLT_WALK;
                    s_d.raddr     = walk_ok ? walk_raddr : '0;
                    s_d.perm      = 3'b000;
                    s_d.dar_valid = !walk_ok && (s_q.kind != ACC_FETCH);
                    s_d.dar       = (!walk_ok && s_q.kind != ACC_FETCH) ? s_q.ea : '0;
                    s_d.state     = S_IDLE;
                end
            end
            default: s_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy           = (s_q.state != S_IDLE);
    assign mem_req        = s_q.mem_req;
    assign mem_addr       = s_q.mem_addr;
    assign walk_start     = s_q.walk_start;
    assign walk_ea        = s_q.ea;
    assign walk_root      = s_q.walk_root;
    assign walk_nls       = s_q.walk_nls;
    assign walk_asize     = s_q.walk_asize;
    assign done           = s_q.done;
    assign resp_fault     = s_q.fault;
    assign resp_raddr     = s_q.raddr;
    assign resp_perm      = s_q.perm;
    assign resp_dar_valid = s_q.dar_valid;
    assign resp_dar       = s_q.dar;
endmodule

// File: rtl/xlate_front.sv
module xlate_front
    import xf_pkg::*;
#(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20,
    parameter int PA_W   = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [63:0]       req_ea,
    input  logic [1:0]        req_kind,
    input  logic              hv_mode,
    input  logic              ir_on,
    input  logic              dr_on,
    input  logic [LPID_W-1:0] cur_lpid,
    input  logic [PID_W-1:0]  cur_pid,
    input  logic [PA_W-1:0]   ptab_base,
    output logic              busy,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              walk_start,
    output logic [63:0]       walk_ea,
    output logic [PA_W-1:0]   walk_root,
    output logic [4:0]        walk_nls,
    output logic [5:0]        walk_asize,
    input  logic              walk_done,
    input  logic              walk_ok,
    input  logic [63:0]       walk_raddr,
    output logic              done,
    output logic [2:0]        resp_fault,
    output logic [63:0]       resp_raddr,
    output logic [2:0]        resp_perm,
    output logic              resp_dar_valid,
    output logic [63:0]       resp_dar
);
    logic              is_real;
    logic [EA_W-1:0]   real_addr;
    logic              q_legal;
    logic [LPID_W-1:0] q_lpid;
    logic [PID_W-1:0]  q_pid;

    xf_mode u_mode (
        .hv        (hv_mode),
        .ir_on     (ir_on),
        .dr_on     (dr_on),
        .kind      (req_kind),
        .ea        (req_ea),
        .is_real   (is_real),
        .real_addr (real_addr)
    );

    xf_quadrant #(.LPID_W(LPID_W), .PID_W(PID_W)) u_quad (
        .hv       (hv_mode),
        .quad     (req_ea[63:62]),
        .cur_lpid (cur_lpid),
        .cur_pid  (cur_pid),
        .legal    (q_legal),
        .lpid     (q_lpid),
        .pid      (q_pid)
    );

    xf_seq #(.LPID_W(LPID_W), .PID_W(PID_W), .PA_W(PA_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ea         (req_ea),
        .req_kind       (req_kind),
        .hv_mode        (hv_mode),
        .is_real        (is_real),
        .real_addr      (real_addr),
        .q_legal        (q_legal),
        .q_lpid         (q_lpid),
        .q_pid          (q_pid),
        .ptab_base      (ptab_base),
        .busy           (busy),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_rvalid     (mem_rvalid),
        .mem_rdata      (mem_rdata),
        .walk_start     (walk_start),
        .walk_ea        (walk_ea),
        .walk_root      (walk_root),
        .walk_nls       (walk_nls),
        .walk_asize     (walk_asize),
        .walk_done      (walk_done),
        .walk_ok        (walk_ok),
        .walk_raddr     (walk_raddr),
        .done           (done),
        .resp_fault     (resp_fault),
        .resp_raddr     (resp_raddr),
        .resp_perm      (resp_perm),
        .resp_dar_valid (resp_dar_valid),
        .resp_dar       (resp_dar)
    );
endmodule

// File: rtl/xlate_front_chk.sv
module xlate_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [63:0] req_ea,
    input logic [1:0]  req_kind,
    input logic        hv_mode,
    input logic        ir_on,
    input logic        dr_on,
    input logic        busy,
    input logic        mem_req,
    input logic        walk_start,
    input logic        done,
    input logic [2:0]  resp_fault,
    input logic [63:0] resp_raddr,
    input logic [2:0]  resp_perm,
    input logic        resp_dar_valid
);
    logic take;
    assign take = req_valid && !busy;

    assert_real_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take && hv_mode && ((req_kind == 2'd2) ? !ir_on : !dr_on)
        |=> done && resp_fault == 3'd0 && resp_perm == 3'b111);

    assert_real_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done && resp_perm != 3'b000 |-> resp_raddr[63:60] == 4'h0);

    assert_guest_seg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take && !hv_mode && (req_ea[63] != req_ea[62])
        |=> done && resp_fault == 3'd1);

    assert_dar_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done && resp_dar_valid |-> resp_fault != 3'd0);

    assert_walk_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |=> !walk_start);

    assert_memreq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_memreq_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_resp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(resp_fault) && $stable(resp_raddr));
endmodule

bind xlate_front xlate_front_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ea         (req_ea),
    .req_kind       (req_kind),
    .hv_mode        (hv_mode),
    .ir_on          (ir_on),
    .dr_on          (dr_on),
    .busy           (busy),
    .mem_req        (mem_req),
    .walk_start     (walk_start),
    .done           (done),
    .resp_fault     (resp_fault),
    .resp_raddr     (resp_raddr),
    .resp_perm      (resp_perm),
    .resp_dar_valid (resp_dar_valid)
);

// File: tb/xlate_front_test.sv
module xlate_front_test;
    localparam int CLK_NS = 10;
    localparam logic [55:0] PT_BASE  = 56'h01_0000;
    localparam logic [55:0] PRB      = 56'h20_0000;
    localparam logic [63:0] PROC_DW0 = (64'd52 << 58) | 64'h34_5600 | 64'd13;
    localparam logic [63:0] WRADDR   = 64'h0000_0ABC_DEF0_1000;
    localparam logic [63:0] LOW60    = 64'h0FFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic        hv;
        logic        ir;
        logic        dr;
        logic [1:0]  kind;
        logic [63:0] ea;
        logic [2:0]  fault;
        logic        rm;
        logic [11:0] lpid;
        logic [19:0] pid;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{1'b1, 1'b0, 1'b1, 2'd2, 64'hF123_4567_89AB_CDEF, 3'd0, 1'b1, 12'd0, 20'd0},
        '{1'b1, 1'b1, 1'b0, 2'd0, 64'hA000_0000_0000_1234, 3'd0, 1'b1, 12'd0, 20'd0},
        '{1'b1, 1'b1, 1'b1, 2'd0, 64'h0000_0000_0000_1000, 3'd0, 1'b0, 12'd0, 20'h123},
        '{1'b1, 1'b1, 1'b1, 2'd1, 64'h4000_0000_0000_2000, 3'd0, 1'b0, 12'd5, 20'h123},
        '{1'b1, 1'b1, 1'b1, 2'd2, 64'h8000_0000_0000_3000, 3'd0, 1'b0, 12'd5, 20'd0},
        '{1'b1, 1'b1, 1'b1, 2'd0, 64'hC000_0000_0000_4000, 3'd0, 1'b0, 12'd0, 20'd0},
        '{1'b0, 1'b1, 1'b0, 2'd0, 64'h0000_0000_0000_5000, 3'd0, 1'b0, 12'd5, 20'h123},
        '{1'b0, 1'b0, 1'b1, 2'd2, 64'hC000_0000_0000_6000, 3'd0, 1'b0, 12'd5, 20'd0},
        '{1'b0, 1'b1, 1'b1, 2'd0, 64'h4000_0000_0000_7000, 3'd1, 1'b0, 12'd0, 20'd0},
        '{1'b0, 1'b1, 1'b1, 2'd2, 64'h8000_0000_0000_8000, 3'd1, 1'b0, 12'd0, 20'd0},
        '{1'b1, 1'b0, 1'b1, 2'd1, 64'h4000_0000_0000_9000, 3'd0, 1'b0, 12'd5, 20'h123}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_ea = '0;
    logic [1:0]  req_kind = '0;
    logic        hv_mode = 1'b0, ir_on = 1'b0, dr_on = 1'b0;
    logic [11:0] cur_lpid = 12'd5;
    logic [19:0] cur_pid = 20'h123;
    logic        busy, mem_req, mem_rvalid = 1'b0;
    logic [55:0] mem_addr;
    logic [63:0] mem_rdata = '0;
    logic        walk_start, walk_done = 1'b0, walk_ok = 1'b1;
    logic [63:0] walk_ea;
    logic [55:0] walk_root;
    logic [4:0]  walk_nls;
    logic [5:0]  walk_asize;
    logic        done, resp_dar_valid;
    logic [2:0]  resp_fault, resp_perm;
    logic [63:0] resp_raddr, resp_dar;

    logic        part_radix = 1'b1;
    logic [4:0]  prsize = 5'd8;
    logic [55:0] rd_log [64];
    int          rd_cnt = 0;
    int          wcnt = 0;
    int          done_cnt = 0;
    logic [63:0] cap_ea = '0;
    logic [55:0] cap_root = '0;
    logic [4:0]  cap_nls = '0;
    logic [5:0]  cap_asize = '0;
    int          tests = 0, fails = 0, base_rd = 0;

    always #(CLK_NS/2) clk = ~clk;

    xlate_front uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_kind(req_kind), .hv_mode(hv_mode), .ir_on(ir_on), .dr_on(dr_on),
        .cur_lpid(cur_lpid), .cur_pid(cur_pid), .ptab_base(PT_BASE),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .walk_start(walk_start), .walk_ea(walk_ea), .walk_root(walk_root),
        .walk_nls(walk_nls), .walk_asize(walk_asize), .walk_done(walk_done),
        .walk_ok(walk_ok), .walk_raddr(WRADDR), .done(done),
        .resp_fault(resp_fault), .resp_raddr(resp_raddr), .resp_perm(resp_perm),
        .resp_dar_valid(resp_dar_valid), .resp_dar(resp_dar)
    );

    function automatic logic [63:0] mem_word(logic [55:0] a);
        if (a >= PRB)  return PROC_DW0;
        else if (a[3]) return {8'h00, PRB} | {59'd0, prsize};
        else           return {part_radix, 63'd0};
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem_word(mem_addr);
            rd_log[rd_cnt % 64] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    always @(posedge clk) begin
        walk_done <= 1'b0;
        if (walk_start) begin
            wcnt      <= 3;
            cap_ea    <= walk_ea;
            cap_root  <= walk_root;
            cap_nls   <= walk_nls;
            cap_asize <= walk_asize;
        end else if (wcnt > 0) begin
            wcnt <= wcnt - 1;
            if (wcnt == 1) walk_done <= 1'b1;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic hv_i, logic ir_i, logic dr_i, logic [1:0] k, logic [63:0] ea_i);
        logic got;
        got = 1'b0;
        @(negedge clk);
        hv_mode = hv_i; ir_on = ir_i; dr_on = dr_i; req_kind = k; req_ea = ea_i;
        req_valid = 1'b1;
        base_rd = rd_cnt;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (done) begin got = 1'b1; break; end
        end
        chk("done seen", {63'd0, got}, 64'd1);
    endtask

    initial begin
        #(CLK_NS * 100000);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs under reset
        chk("R1 done", {63'd0, done}, 64'd0);
        chk("R1 busy", {63'd0, busy}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mem_req/walk_start", {62'd0, mem_req, walk_start}, 64'd0);
        chk("R1 fault", {61'd0, resp_fault}, 64'd0);

        foreach (VECS[i]) begin
            vec_t v;
            string tag;
            v = VECS[i];
            tag = v.rm ? "R2" : (v.fault == 3'd1) ? "R5" : v.hv ? "R3" : "R4";
            issue(v.hv, v.ir, v.dr, v.kind, v.ea);
            chk(tag, {61'd0, resp_fault}, {61'd0, v.fault});
            if (v.rm) begin
                chk("R2 raddr", resp_raddr, v.ea & LOW60);
                chk("R2 perm", {61'd0, resp_perm}, 64'd7);
                chk("R2 no read", 64'(rd_cnt - base_rd), 64'd0);
            end else if (v.fault == 3'd1) begin
                chk("R5 dar_valid", {63'd0, resp_dar_valid}, {63'd0, v.kind != 2'd2});
                chk("R5 dar", resp_dar, (v.kind != 2'd2) ? v.ea : 64'd0);
                chk("R5 no read", 64'(rd_cnt - base_rd), 64'd0);
            end else begin
                chk({tag, " reads"}, 64'(rd_cnt - base_rd), 64'd3);
                chk({tag, " lpid"}, 64'(rd_log[base_rd % 64]), 64'(PT_BASE + {v.lpid, 4'h0}));
                chk({tag, " dw1"}, 64'(rd_log[(base_rd + 1) % 64]), 64'(PT_BASE + {v.lpid, 4'h0} + 56'd8));
                chk({tag, " pid"}, 64'(rd_log[(base_rd + 2) % 64]), 64'(PRB + {v.pid, 4'h0}));
                chk("R10 raddr", resp_raddr, WRADDR);
                chk("R10 perm", {61'd0, resp_perm}, 64'd0);
            end
        end

        // R9: walker handoff fields from the last translated request
        chk("R9 ea", cap_ea, 64'h4000_0000_0000_9000);
        chk("R9 root", 64'(cap_root), 64'h34_5600);
        chk("R9 nls", 64'(cap_nls), 64'd13);
        chk("R9 asize", 64'(cap_asize), 64'd52);

        // R6: radix flag clear
        part_radix = 1'b0;
        issue(1'b1, 1'b1, 1'b1, 2'd0, 64'h4000_0000_0000_1000);
        chk("R6 fault", {61'd0, resp_fault}, 64'd3);
        chk("R6 reads", 64'(rd_cnt - base_rd), 64'd1);
        part_radix = 1'b1;

        // R7: partition 0 in guest state
        cur_lpid = 12'd0;
        issue(1'b0, 1'b1, 1'b1, 2'd1, 64'h0000_0000_0000_2000);
        chk("R7 fault", {61'd0, resp_fault}, 64'd3);
        chk("R5 dar on store fault", resp_dar, 64'h0000_0000_0000_2000);
        cur_lpid = 12'd5;

        // R8: table bound, size field 0 -> 256 entries
        prsize = 5'd0;
        cur_pid = 20'd256;
        issue(1'b1, 1'b1, 1'b1, 2'd0, 64'h4000_0000_0000_3000);
        chk("R8 over fault", {61'd0, resp_fault}, 64'd2);
        chk("R8 over reads", 64'(rd_cnt - base_rd), 64'd2);
        cur_pid = 20'd255;
        issue(1'b1, 1'b1, 1'b1, 2'd0, 64'h4000_0000_0000_3000);
        chk("R8 edge fault", {61'd0, resp_fault}, 64'd0);
        chk("R8 edge reads", 64'(rd_cnt - base_rd), 64'd3);
        prsize = 5'd8;
        cur_pid = 20'h123;

        // R10: walker reports failure on a fetch
        walk_ok = 1'b0;
        issue(1'b1, 1'b1, 1'b1, 2'd2, 64'h4000_0000_0000_4000);
        chk("R10 fault", {61'd0, resp_fault}, 64'd4);
        chk("R10 raddr", resp_raddr, 64'd0);
        chk("R10 fetch dar", {63'd0, resp_dar_valid}, 64'd0);
        walk_ok = 1'b1;

        // R11: requests while busy are dropped, response holds
        begin
            int d0;
            logic got;
            got = 1'b0;
            @(negedge clk);
            d0 = done_cnt;
            hv_mode = 1'b1; ir_on = 1'b1; dr_on = 1'b1; req_kind = 2'd0;
            req_ea = 64'h4000_0000_0000_5000; req_valid = 1'b1;
            @(negedge clk);
            dr_on = 1'b0; req_ea = 64'hF000_0000_0000_0001;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            for (int i = 0; i < 60; i++) begin
                if (done) begin got = 1'b1; break; end
                @(negedge clk);
            end
            chk("R11 done", {63'd0, got}, 64'd1);
            chk("R11 walked result", resp_raddr, WRADDR);
            repeat (6) @(negedge clk);
            chk("R11 single response", 64'(done_cnt - d0), 64'd1);
            chk("R11 hold raddr", resp_raddr, WRADDR);
            chk("R11 hold fault", {61'd0, resp_fault}, 64'd0);
            chk("R11 idle", {63'd0, busy}, 64'd0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule